// File: doc/BRIEF.md
# Two-Tone Sine Synthesizer

This block produces a stream of 8-bit unsigned samples that carry the sum of two sine tones. A free-running divider turns the system clock into a sample strobe. On each strobe, two phase accumulators each add their own increment. The upper bits of each accumulator then address one shared sine table, and the two table reads are merged into the output sample.

The increments come straight in as inputs, so frequency is set by the caller (frequency = increment × sample rate / 2^16). When both increments are equal, the block treats the request as one tone and outputs tone A's table value unchanged. When they differ, it outputs the mean of the two reads. An enable input freezes synthesis. While it is low the phases and the sample hold, no valid pulse appears, and the divider keeps its rhythm.

Top module: `dual_tone_synth`

## Requirements
- R1: The divider wraps every CLK_DIV (default 200) clocks. While `en_i` is high, `valid_o` is a single-cycle pulse once per period. The first pulse is visible 200 clocks after reset is released.
- R2: Each 16-bit phase accumulator adds its increment modulo 2^16 on every enabled strobe.
- R3: The table index is the top 8 bits of the freshly updated phase. For index i with k = i mod 128 and u = k(128−k), entry(i) = 128 + m for i < 128 and 128 − m otherwise, where m = floor(127·16·u / (5·128² − 4u)). So index 64 gives 255, index 0 and 128 give 128, and index 192 gives 1.
- R4: When `inc_a_i` equals `inc_b_i` at the strobe, the sample is tone A's table value.
- R5: When the increments differ, the sample is (entryA + entryB) >> 1, formed from a 9-bit sum so no carry is lost.
- R6: `sample_o` changes only at the edge that raises `valid_o`.
- R7: While `en_i` is low at the strobe edge, no valid pulse is produced and both phases and the sample are held. The divider keeps counting, so later strobes keep their original spacing.
- R8: A synchronous active-high `rst` clears the divider, both phases, the sample and `valid_o` to zero. It takes priority over a coincident strobe.
- R9: Increments are used only at the strobe edge. Values applied between strobes have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Synthesis enable |
| inc_a_i | input | 16 | Phase increment of tone A |
| inc_b_i | input | 16 | Phase increment of tone B |
| sample_o | output | 8 | Mixed unsigned sample |
| valid_o | output | 1 | One-cycle pulse marking a new sample |

## Verification
The strobe edge is where other actions can collide with sample production. The bench lines up a falling enable, a change of both increments, and a reset on exactly the clock where the divider wraps. It finds that clock by watching its own behavioural divider and drives the input on the preceding falling edge. A reference model written from the requirements is compared with both outputs on every clock. Directed checks confirm that the gated strobe emits nothing, that the new increments are taken in the same edge, and that reset wins with an all-zero result.

// File: rtl/dts_pkg.sv
package dts_pkg;

   // Magnitude of a half-sine sample at position k of a half period of
   // length half, scaled to amp, using a rational sine approximation.
   function automatic int unsigned sine_mag(int unsigned k, int unsigned half,
                                            int unsigned amp);
      longint unsigned u;
      longint unsigned num;
      longint unsigned den;
      u   = longint'(k) * longint'(half - k);
      num = longint'(amp) * 16 * u;
      den = 5 * longint'(half) * longint'(half) - 4 * u;
      return int'(num / den);
   endfunction

endpackage

// File: rtl/tone_tick_div.sv
module tone_tick_div #(
   parameter int unsigned CLK_DIV = 200
) (
   input  logic clk,
   input  logic rst,
   output logic tick_o
);
   localparam int unsigned CW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

   logic [CW-1:0] cnt_q;

   if (CLK_DIV < 2) begin : g_bad_div
      $error("tone_tick_div: CLK_DIV must be at least 2");
   end

   assign tick_o = (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (rst)         cnt_q <= '0;
      else if (tick_o) cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end

   // R1: two strobes are never adjacent
   p_tick_gap_r1: assert property (@(posedge clk) disable iff (rst)
      tick_o |=> !tick_o);

endmodule

// File: rtl/tone_phase_acc.sv
module tone_phase_acc #(
   parameter int unsigned ACC_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step_i,
   input  logic [ACC_W-1:0] inc_i,
   output logic [ACC_W-1:0] phase_nxt_o
);
   logic [ACC_W-1:0] phase_q;

   if (ACC_W < 2) begin : g_bad_acc
      $error("tone_phase_acc: ACC_W too small");
   end

   assign phase_nxt_o = phase_q + inc_i;

   always_ff @(posedge clk) begin
      if (rst)         phase_q <= '0;
      else if (step_i) phase_q <= phase_nxt_o;
   end

   // R7: phase frozen without a step
   p_phase_hold_r7: assert property (@(posedge clk) disable iff (rst)
      !step_i |=> $stable(phase_q));

endmodule

// File: rtl/tone_sine_rom.sv
module tone_sine_rom
   import dts_pkg::*;
#(
   parameter int unsigned IDX_W   = 8,
   parameter int unsigned SMP_W   = 8,
   parameter int unsigned NPORT   = 2,
   parameter bit          QUARTER = 1'b1
) (
   input  logic [NPORT*IDX_W-1:0] idx_i,
   output logic [NPORT*SMP_W-1:0] val_o
);
   localparam int unsigned N   = 1 << IDX_W;
   localparam int unsigned P   = N / 2;
   localparam int unsigned Q   = N / 4;
   localparam int unsigned MID = 1 << (SMP_W - 1);
   localparam int unsigned AMP = MID - 1;
   localparam int unsigned QW  = $clog2(Q + 1);

   if (IDX_W < 3 || IDX_W > 12) begin : g_bad_idx
      $error("tone_sine_rom: IDX_W out of range");
   end
   if (SMP_W < 2) begin : g_bad_smp
      $error("tone_sine_rom: SMP_W too small");
   end

   if (QUARTER) begin : g_quarter
      logic [SMP_W-1:0] mag_tab [Q+1];
      for (genvar g = 0; g <= Q; g++) begin : g_fill
         assign mag_tab[g] = SMP_W'(sine_mag(g, P, AMP));
      end
      for (genvar p = 0; p < NPORT; p++) begin : g_port
         logic [IDX_W-1:0] idx;
         logic             neg;
         logic [IDX_W-1:0] kw;
         logic [IDX_W-1:0] kf;
         logic [SMP_W-1:0] mag;
         assign idx = idx_i[p*IDX_W +: IDX_W];
         assign neg = idx[IDX_W-1];
         assign kw  = {1'b0, idx[IDX_W-2:0]};
         assign kf  = (kw > IDX_W'(Q)) ? (IDX_W'(P) - kw) : kw;
         assign mag = mag_tab[QW'(kf)];
         assign val_o[p*SMP_W +: SMP_W] = neg ? (SMP_W'(MID) - mag)
                                              : (SMP_W'(MID) + mag);
      end
   end else begin : g_full
      logic [SMP_W-1:0] full_tab [N];
      for (genvar g = 0; g < N; g++) begin : g_fill
         if (g < P) begin : g_pos
            assign full_tab[g] = SMP_W'(MID + sine_mag(g, P, AMP));
         end else begin : g_neg
            assign full_tab[g] = SMP_W'(MID - sine_mag(g - P, P, AMP));
         end
      end
      for (genvar p = 0; p < NPORT; p++) begin : g_port
         assign val_o[p*SMP_W +: SMP_W] = full_tab[idx_i[p*IDX_W +: IDX_W]];
      end
   end

endmodule

// File: rtl/tone_mix.sv
module tone_mix #(
   parameter int unsigned SMP_W = 8,
   parameter int unsigned INC_W = 16
) (
   input  logic [INC_W-1:0] inc_a_i,
   input  logic [INC_W-1:0] inc_b_i,
   input  logic [SMP_W-1:0] val_a_i,
   input  logic [SMP_W-1:0] val_b_i,
   output logic [SMP_W-1:0] mix_o
);
   logic [SMP_W:0] sum;

   assign sum   = {1'b0, val_a_i} + {1'b0, val_b_i};
   assign mix_o = (inc_a_i == inc_b_i) ? val_a_i : sum[SMP_W:1];

   // R5: the mean lies between both reads (no lost carry)
   always_comb begin
      p_no_overflow_r5: assert ((inc_a_i == inc_b_i) ||
         ((mix_o >= val_a_i || mix_o >= val_b_i) &&
          (mix_o <= val_a_i || mix_o <= val_b_i)));
   end

endmodule

// File: rtl/dual_tone_synth.sv
module dual_tone_synth #(
   parameter int unsigned CLK_DIV = 200,
   parameter int unsigned ACC_W   = 16,
   parameter int unsigned IDX_W   = 8,
   parameter int unsigned SMP_W   = 8,
   parameter bit          QUARTER = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en_i,
   input  logic [ACC_W-1:0] inc_a_i,
   input  logic [ACC_W-1:0] inc_b_i,
   output logic [SMP_W-1:0] sample_o,
   output logic             valid_o
);
   localparam int unsigned NT = 2;

   if (ACC_W < IDX_W) begin : g_bad_widths
      $error("dual_tone_synth: ACC_W must cover IDX_W");
   end

   logic                   tick;
   logic                   strobe;
   logic [ACC_W-1:0]       inc_w   [NT];
   logic [ACC_W-1:0]       phase_n [NT];
   logic [NT*IDX_W-1:0]    idx_bus;
   logic [NT*SMP_W-1:0]    val_bus;
   logic [SMP_W-1:0]       mix;

   assign inc_w[0] = inc_a_i;
   assign inc_w[1] = inc_b_i;
   assign strobe   = tick & en_i;

   tone_tick_div #(.CLK_DIV(CLK_DIV)) u_div (
      .clk(clk), .rst(rst), .tick_o(tick));

   for (genvar t = 0; t < NT; t++) begin : g_tone
      tone_phase_acc #(.ACC_W(ACC_W)) u_acc (
         .clk(clk), .rst(rst), .step_i(strobe),
         .inc_i(inc_w[t]), .phase_nxt_o(phase_n[t]));
      assign idx_bus[t*IDX_W +: IDX_W] = phase_n[t][ACC_W-1 -: IDX_W];
   end

   tone_sine_rom #(.IDX_W(IDX_W), .SMP_W(SMP_W), .NPORT(NT),
                   .QUARTER(QUARTER)) u_rom (
      .idx_i(idx_bus), .val_o(val_bus));

   tone_mix #(.SMP_W(SMP_W), .INC_W(ACC_W)) u_mix (
      .inc_a_i(inc_a_i), .inc_b_i(inc_b_i),
      .val_a_i(val_bus[0 +: SMP_W]), .val_b_i(val_bus[SMP_W +: SMP_W]),
      .mix_o(mix));

   always_ff @(posedge clk) begin
      if (rst) begin
         sample_o <= '0;
         valid_o  <= 1'b0;
      end else begin
         valid_o <= strobe;
         if (strobe) sample_o <= mix;
      end
   end

   // R7: no valid pulse follows a disabled cycle
   p_gated_valid_r7: assert property (@(posedge clk) disable iff (rst)
      !en_i |=> !valid_o);
   // R6: sample moves only together with valid
   p_sample_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (!valid_o && !$past(rst)) |-> $stable(sample_o));
   // R8: reset leaves a zero sample and no pulse
   p_reset_clear_r8: assert property (@(posedge clk)
      $past(rst) |-> (sample_o == '0 && !valid_o));

endmodule

// File: tb/sim_dual_tone_synth.sv
`timescale 1ns/1ps
module sim_dual_tone_synth;
   localparam int DIV = 200;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        en_i = 1'b0;
   logic [15:0] inc_a_i = '0;
   logic [15:0] inc_b_i = '0;
   logic [7:0]  sample_o;
   logic        valid_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // behavioural reference state
   int m_cnt = 0;
   int m_acc_a = 0;
   int m_acc_b = 0;
   int m_out = 0;
   int m_valid = 0;

   always #2.5 clk = ~clk;

   dual_tone_synth u0 (
      .clk(clk), .rst(rst), .en_i(en_i), .inc_a_i(inc_a_i),
      .inc_b_i(inc_b_i), .sample_o(sample_o), .valid_o(valid_o));

   function automatic int ref_tbl(int i);
      int k, u, m;
      k = i % 128;
      u = k * (128 - k);
      m = (127 * 16 * u) / (5 * 128 * 128 - 4 * u);
      return (i < 128) ? 128 + m : 128 - m;
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_cnt = 0; m_acc_a = 0; m_acc_b = 0; m_out = 0; m_valid = 0;
      end else begin
         int va, vb;
         bit tk;
         tk = (m_cnt == DIV - 1);
         m_cnt = tk ? 0 : m_cnt + 1;
         m_valid = 0;
         if (tk && en_i) begin
            m_acc_a = (m_acc_a + int'(inc_a_i)) % 65536;
            m_acc_b = (m_acc_b + int'(inc_b_i)) % 65536;
            va = ref_tbl(m_acc_a / 256);
            vb = ref_tbl(m_acc_b / 256);
            m_out = (inc_a_i == inc_b_i) ? va : (va + vb) / 2;
            m_valid = 1;
         end
      end
   end

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // every-clock comparison with the model
   always @(negedge clk) begin
      if (!done) begin
         chk("R1 valid", int'(valid_o), m_valid);
         chk("R2 R4 R5 sample", int'(sample_o), m_out);
      end
   end

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      summary();
   end

   task automatic wait_valid(output int n);
      n = 0;
      do begin @(negedge clk); n++; end while (!valid_o);
   endtask

   task automatic to_wrap();
      do @(negedge clk); while (m_cnt != DIV - 1);
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      int n;
      logic [7:0] held;
      repeat (3) @(negedge clk);
      chk("R8 reset sample", int'(sample_o), 0);
      chk("R8 reset valid", int'(valid_o), 0);

      // R3/R4: equal increments, quarter-period steps
      inc_a_i = 16'h4000; inc_b_i = 16'h4000; en_i = 1'b1;
      rst = 1'b0;
      wait_valid(n); chk("R1 first pulse", n, DIV); chk("R3 R4 idx64", int'(sample_o), 255);
      wait_valid(n); chk("R1 period", n, DIV);      chk("R3 R4 idx128", int'(sample_o), 128);
      wait_valid(n); chk("R1 period", n, DIV);      chk("R3 R4 idx192", int'(sample_o), 1);
      @(negedge clk); chk("R1 single cycle", int'(valid_o), 0);

      // R5: differing increments
      do_reset();
      inc_a_i = 16'h4000; inc_b_i = 16'h0000;
      wait_valid(n); chk("R5 mean 255/128", int'(sample_o), 191);
      wait_valid(n); chk("R5 mean 128/128", int'(sample_o), 128);
      wait_valid(n); chk("R5 mean 1/128", int'(sample_o), 64);

      // R2: wrap-around and assorted increments
      inc_a_i = 16'hFFFF; inc_b_i = 16'h8001;
      repeat (6) wait_valid(n);
      inc_a_i = 16'h0123; inc_b_i = 16'h0123;
      repeat (4) wait_valid(n);
      inc_a_i = 16'h1A2B; inc_b_i = 16'h07FF;
      repeat (8) wait_valid(n);
      chk("R2 wrap sample", int'(sample_o), m_out);

      // R7: enable falls on the wrap cycle
      to_wrap(); en_i = 1'b0; held = sample_o;
      @(negedge clk);
      chk("R7 no pulse at gated strobe", int'(valid_o), 0);
      chk("R7 sample held", int'(sample_o), int'(held));
      repeat (3 * DIV) begin
         @(negedge clk);
         if (valid_o || sample_o != held) chk("R7 hold window", int'(sample_o), int'(held));
      end
      chk("R7 held after window", int'(sample_o), int'(held));
      en_i = 1'b1;
      wait_valid(n); chk("R7 spacing kept", n % DIV, (m_cnt + 0) % DIV);

      // R9: increments change on the wrap cycle and between strobes
      to_wrap(); inc_a_i = 16'h2000; inc_b_i = 16'h2000;
      @(negedge clk); chk("R9 taken at strobe", int'(sample_o), m_out);
      repeat (50) @(negedge clk);
      inc_b_i = 16'h5555; held = sample_o;
      repeat (50) @(negedge clk);
      chk("R9 no effect between strobes", int'(sample_o), int'(held));
      inc_b_i = 16'h2000;
      wait_valid(n); chk("R9 R4 equal at strobe", int'(sample_o), m_out);

      // R8: reset on the wrap cycle
      to_wrap(); rst = 1'b1;
      @(negedge clk);
      chk("R8 reset beats strobe sample", int'(sample_o), 0);
      chk("R8 reset beats strobe valid", int'(valid_o), 0);
      rst = 1'b0;
      wait_valid(n); chk("R8 restart period", n, DIV);
      repeat (3) @(negedge clk);
      summary();
   end
endmodule